// File: doc/BRIEF.md
# Converter Configuration Port (SPI Register Slave)

This block is the device side of the serial configuration port of a data converter front end. A host talks to it over a four-wire SPI link in mode 0. Each chip-select window opens with one address byte. Bit 7 of that byte picks read (1) or write (0), and bits 6:0 give the starting register. Data bytes follow, and the register address steps up by one after each of them. The block keeps a small register file, answers with fixed identification words and a status byte, and drives the configuration words that the rest of the converter consumes.

Two traffic patterns are handled outside normal register access. The first is an 18-byte reset sequence sent inside one chip-select window: every byte is 0xFF, except the bytes at positions 5, 11 and 17, which are 0xFE. This sequence restores every register and starts a quiet period. The second is the conversion mode, entered through a command register. While the block is in conversion mode, frames no longer touch the registers, and a single 0xA8 byte at the start of a window returns the port to register mode. The `conv_active` flag tells the datapath which of the two modes is in force.

The SPI pins are brought into the system clock domain through two-flop synchronisers, and all SCLK edges are detected at the system clock rate.

Top module: `cfg_spi_port`

## Requirements
- R1: MOSI is sampled on rising SCLK, and MISO changes only after falling SCLK, MSB first. In a frame, byte 0 is the address byte with bit 7 set for a read. Each later byte reads or writes the next address in turn. MISO is 0 whenever chip select is high.
- R2: A read from an address outside 0x00–0x06, 0x0A–0x11, 0x20–0x2F and 0x40–0x45 returns 0x00.
- R3: Only 0x00–0x02, 0x0A, 0x0E–0x11, 0x20–0x2F and 0x40–0x41 accept writes. A write to any other address is discarded, and a read frame changes no configuration output.
- R4: The product identifier (parameter, default 0x0072) reads most significant byte first at 0x04/0x05. The vendor identifier 0x0456 reads the same way at 0x0C/0x0D.
- R5: Address 0x0A is a scratch byte that reads back the last value written to it.
- R6: Bits 1:0 of 0x02 hold the power mode, which drives `pwr_mode`. `low_power` is high exactly when the field is 3, and writing 0 clears it.
- R7: Writing a byte with bit 0 set to 0x20 raises `conv_active`, and 0x20 reads as 0x00. While `conv_active` is high, no frame reads or writes registers. A 0xA8 byte as the first byte of a window lowers `conv_active`, and any other byte leaves it high.
- R8: Once all 18 bytes of the reset sequence arrive in one window, in either mode, every register returns to its reset value, `conv_active` drops, and the reset flag is set. A sequence with any byte wrong causes no reset.
- R9: A frame that starts less than RST_CYCLES clocks after a power-on reset or a soft reset is ignored entirely.
- R10: Address 0x41 reads as {ready, reset_flag, 6'b0}. The ready bit is 1 once the quiet period has ended. The reset flag is set by either reset and cleared by writing 1 to bit 6.
- R11: Raising chip select discards any partial byte, so the next window starts again with an address byte.
- R12: The configuration outputs map as follows: `op_mode` is 0x21[1:0], `avg_cfg` is 0x23, `gp_route` is 0x24, `irq_route` is 0x25, `timer_cfg` is 0x27 and `gain_word` is {0x2E, 0x2F}. All of them reset to 0, except `gain_word`, which resets to 0x8000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock (mode 0) |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| conv_active | output | 1 | High while conversion mode is in force |
| low_power | output | 1 | Power mode field equals 3 |
| pwr_mode | output | 2 | Power mode field |
| op_mode | output | 2 | Converter operating mode field |
| avg_cfg | output | 8 | Averaging setting |
| gp_route | output | 8 | General-purpose pin routing |
| irq_route | output | 8 | Interrupt routing |
| timer_cfg | output | 8 | Conversion timer setting |
| gain_word | output | 16 | Gain word, 0x8000 is unity |

## Verification
The assertions take for granted that the SCLK phases and the chip-select setup and hold times each last several system clocks. Under that assumption the synchroniser delay never merges two edges, and a prefetched read byte is always loaded before the falling edge that shifts it out. The bench holds each SCLK phase for eight clocks and leaves at least that long around every chip-select transition. Chip select stays high through reset, and the bench changes MOSI only while SCLK is low, so every sampled bit is settled.

// File: rtl/cfg_spi_port.sv
module cfg_spi_port #(
  parameter int          RST_CYCLES = 1000,
  parameter logic [15:0] PROD_ID    = 16'h0072,
  parameter logic [15:0] VENDOR_ID  = 16'h0456
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        mosi,
  output logic        miso,
  output logic        conv_active,
  output logic        low_power,
  output logic [1:0]  pwr_mode,
  output logic [1:0]  op_mode,
  output logic [7:0]  avg_cfg,
  output logic [7:0]  gp_route,
  output logic [7:0]  irq_route,
  output logic [7:0]  timer_cfg,
  output logic [15:0] gain_word
);
  localparam int          NREG    = 128;
  localparam int          HOLD_W  = $clog2(RST_CYCLES + 1);
  localparam int          PAT_LEN = 18;
  localparam logic [7:0]  EXIT_CMD = 8'hA8;
  localparam logic [6:0]  A_CMD    = 7'h20;
  localparam logic [6:0]  A_STAT   = 7'h41;
  localparam logic [6:0]  A_GAIN_H = 7'h2E;

  logic [2:0] sclk_q, cs_q;
  logic [1:0] mosi_q;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sr;
  logic [4:0] byte_pos;
  logic       pat_ok, frame_live, rd_frame, conv_q, rst_flag, miso_q;
  logic [6:0] cur_addr;
  logic [7:0] tx_sr;
  logic [HOLD_W-1:0] hold_cnt;
  logic [7:0] mem [NREG];

  wire sclk_rise = sclk_q[1] & ~sclk_q[2];
  wire sclk_fall = ~sclk_q[1] & sclk_q[2];
  wire cs_live   = ~cs_q[1];
  wire cs_start  = ~cs_q[1] & cs_q[2];
  wire mosi_s    = mosi_q[1];
  wire hold_busy = hold_cnt != '0;

  wire [7:0] rx_byte   = {rx_sr, mosi_s};
  wire       byte_done = cs_live & sclk_rise & (bit_cnt == 3'd7);
  wire       first     = byte_pos == 5'd0;
  wire [7:0] pat_exp   = (byte_pos == 5'd5 || byte_pos == 5'd11 || byte_pos == 5'd17) ? 8'hFE : 8'hFF;
  wire       pat_hit   = byte_done & frame_live & pat_ok & (byte_pos == 5'(PAT_LEN - 1)) & (rx_byte == pat_exp);
  wire       acc       = byte_done & frame_live & ~pat_hit;
  wire       exit_hit  = acc & conv_q & first & (rx_byte == EXIT_CMD);
  wire       addr_ph   = acc & ~conv_q & first;
  wire       data_ph   = acc & ~conv_q & ~first;
  wire       wr_en     = data_ph & ~rd_frame;

  function automatic logic readable(input logic [6:0] a);
    return (a <= 7'h06) || (a >= 7'h0A && a <= 7'h11) ||
           (a >= 7'h20 && a <= 7'h2F) || (a >= 7'h40 && a <= 7'h45);
  endfunction

  function automatic logic storable(input logic [6:0] a);
    return (a <= 7'h02) || (a == 7'h0A) || (a >= 7'h0E && a <= 7'h11) ||
           (a >= 7'h21 && a <= 7'h2F) || (a == 7'h40);
  endfunction

  function automatic logic [7:0] rd_val(input logic [6:0] a);
    if (!readable(a)) return 8'h00;
    case (a)
      7'h04:   return PROD_ID[15:8];
      7'h05:   return PROD_ID[7:0];
      7'h0C:   return VENDOR_ID[15:8];
      7'h0D:   return VENDOR_ID[7:0];
      A_CMD:   return 8'h00;
      A_STAT:  return {~hold_busy, rst_flag, 6'b0};
      default: return mem[a];
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      cs_q   <= {cs_q[1:0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      rx_sr      <= '0;
      byte_pos   <= '0;
      pat_ok     <= 1'b1;
      frame_live <= 1'b0;
      rd_frame   <= 1'b0;
      cur_addr   <= '0;
      tx_sr      <= '0;
      miso_q     <= 1'b0;
    end else if (!cs_live) begin
      bit_cnt  <= '0;
      byte_pos <= '0;
      pat_ok   <= 1'b1;
      tx_sr    <= '0;
      miso_q   <= 1'b0;
    end else begin
      if (cs_start) frame_live <= ~hold_busy;
      if (pat_hit)  frame_live <= 1'b0;
      if (sclk_rise) begin
        rx_sr   <= {rx_sr[5:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (byte_done) begin
        if (byte_pos != 5'd31) byte_pos <= byte_pos + 5'd1;
        pat_ok <= pat_ok & (rx_byte == pat_exp);
      end
      if (addr_ph) begin
        rd_frame <= rx_byte[7];
        cur_addr <= rx_byte[6:0];
        tx_sr    <= rx_byte[7] ? rd_val(rx_byte[6:0]) : 8'h00;
      end else if (data_ph) begin
        cur_addr <= cur_addr + 7'd1;
        tx_sr    <= rd_frame ? rd_val(cur_addr + 7'd1) : 8'h00;
      end
      if (sclk_fall) begin
        miso_q <= tx_sr[7];
        tx_sr  <= {tx_sr[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_q   <= 1'b0;
      rst_flag <= 1'b1;
      hold_cnt <= HOLD_W'(RST_CYCLES);
    end else if (pat_hit) begin
      conv_q   <= 1'b0;
      rst_flag <= 1'b1;
      hold_cnt <= HOLD_W'(RST_CYCLES);
    end else begin
      if (hold_busy) hold_cnt <= hold_cnt - 1'b1;
      if (exit_hit) conv_q <= 1'b0;
      else if (wr_en && cur_addr == A_CMD && rx_byte[0]) conv_q <= 1'b1;
      if (wr_en && cur_addr == A_STAT && rx_byte[6]) rst_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= (i == int'(A_GAIN_H)) ? 8'h80 : 8'h00;
    end else if (pat_hit) begin
      for (int i = 0; i < NREG; i++) mem[i] <= (i == int'(A_GAIN_H)) ? 8'h80 : 8'h00;
    end else if (wr_en && storable(cur_addr)) begin
      mem[cur_addr] <= rx_byte;
    end
  end

  assign miso        = miso_q;
  assign conv_active = conv_q;
  assign pwr_mode    = mem[7'h02][1:0];
  assign low_power   = &mem[7'h02][1:0];
  assign op_mode     = mem[7'h21][1:0];
  assign avg_cfg     = mem[7'h23];
  assign gp_route    = mem[7'h24];
  assign irq_route   = mem[7'h25];
  assign timer_cfg   = mem[7'h27];
  assign gain_word   = {mem[7'h2E], mem[7'h2F]};
endmodule

// File: rtl/cfg_spi_port_chk.sv
module cfg_spi_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_live,
  input logic        miso,
  input logic        conv_active,
  input logic        rst_flag,
  input logic        hold_busy,
  input logic        pat_hit,
  input logic        exit_hit,
  input logic        byte_done,
  input logic        frame_live,
  input logic        rd_frame,
  input logic        first,
  input logic [1:0]  pwr_mode,
  input logic [1:0]  op_mode,
  input logic [7:0]  avg_cfg,
  input logic [7:0]  gp_route,
  input logic [7:0]  irq_route,
  input logic [7:0]  timer_cfg,
  input logic [15:0] gain_word
);
  p_miso_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_live |=> !miso);

  p_read_no_side_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && frame_live && rd_frame && !first && !pat_hit) |=>
      $stable({pwr_mode, op_mode, avg_cfg, gp_route, irq_route, timer_cfg, gain_word, conv_active}));

  p_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exit_hit |=> !conv_active);

  p_conv_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_active) |-> $past(byte_done && frame_live && !rd_frame));

  p_soft_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pat_hit |=> (!conv_active && rst_flag && hold_busy && gain_word == 16'h8000));

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_busy |-> !conv_active);

  p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_flag) |-> $past(byte_done && frame_live && !rd_frame));
endmodule

bind cfg_spi_port cfg_spi_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_live(cs_live), .miso(miso),
  .conv_active(conv_active), .rst_flag(rst_flag), .hold_busy(hold_busy),
  .pat_hit(pat_hit), .exit_hit(exit_hit), .byte_done(byte_done),
  .frame_live(frame_live), .rd_frame(rd_frame), .first(first),
  .pwr_mode(pwr_mode), .op_mode(op_mode), .avg_cfg(avg_cfg),
  .gp_route(gp_route), .irq_route(irq_route), .timer_cfg(timer_cfg),
  .gain_word(gain_word)
);

// File: tb/cfg_spi_port_tb_top.sv
module cfg_spi_port_tb_top;
  localparam int CLK_P     = 10;
  localparam int HALF      = 8;
  localparam int HOLD_WAIT = 1200;
  localparam int NV        = 23;
  // {write, addr[6:0]}, data-or-expected, requirement number
  localparam logic [23:0] VEC [NV] = '{
    24'h8A5A05, 24'h0A5A05,                 // R5 scratch
    24'h0C0404, 24'h0D5604,                 // R4 vendor
    24'h040004, 24'h057204,                 // R4 product
    24'h837703, 24'h030003,                 // R3 read-only id byte
    24'h120002,                             // R2 unmapped
    24'hC03C03, 24'h403C03,                 // R3 writable 0x40
    24'h070002,                             // R2 unmapped
    24'h2E800C, 24'h2F000C,                 // R12 gain reset
    24'h41C00A, 24'hC1400A, 24'h41800A,     // R10 flag W1C
    24'hA3090C, 24'h23090C,                 // R12 averaging
    24'h820306, 24'h020306,                 // R6 power mode
    24'h869903, 24'h060003                  // R3 grade read-only
  };

  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, mosi = 0;
  logic miso, conv_active, low_power;
  logic [1:0] pwr_mode, op_mode;
  logic [7:0] avg_cfg, gp_route, irq_route, timer_cfg;
  logic [15:0] gain_word;
  logic [7:0] tx_buf [20];
  logic [7:0] rx_buf [20];
  logic [7:0] rd;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  cfg_spi_port dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .conv_active(conv_active), .low_power(low_power), .pwr_mode(pwr_mode),
    .op_mode(op_mode), .avg_cfg(avg_cfg), .gp_route(gp_route),
    .irq_route(irq_route), .timer_cfg(timer_cfg), .gain_word(gain_word)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = tx[i];
      wait_clk(HALF);
      sclk = 1;
      rx[i] = miso;
      wait_clk(HALF);
      sclk = 0;
    end
  endtask

  task automatic run_frame(input int n);
    logic [7:0] r;
    cs_n = 0;
    wait_clk(HALF);
    for (int k = 0; k < n; k++) begin
      send_bits(tx_buf[k], 8, r);
      rx_buf[k] = r;
    end
    wait_clk(HALF);
    cs_n = 1;
    wait_clk(2 * HALF);
  endtask

  task automatic reg_wr(input logic [6:0] a, input logic [7:0] d);
    tx_buf[0] = {1'b0, a};
    tx_buf[1] = d;
    run_frame(2);
  endtask

  task automatic reg_rd(input logic [6:0] a, output logic [7:0] d);
    tx_buf[0] = {1'b1, a};
    tx_buf[1] = 8'h00;
    run_frame(2);
    d = rx_buf[1];
  endtask

  task automatic load_pattern(input bit good);
    for (int k = 0; k < 18; k++)
      tx_buf[k] = (k == 5 || k == 17 || (k == 11 && good)) ? 8'hFE : 8'hFF;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R9 watchdog: actual done=0 expected done=1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    wait_clk(5);
    rst_n = 1;
    wait_clk(2);
    check("R12 reset gain", gain_word, 16'h8000);
    check("R12 reset avg", avg_cfg, 8'h00);
    check("R7 reset conv", conv_active, 1'b0);
    check("R6 reset pwr", pwr_mode, 2'd0);
    check("R1 reset miso", miso, 1'b0);

    reg_wr(7'h0A, 8'h11);               // inside quiet period
    wait_clk(HOLD_WAIT);
    reg_rd(7'h0A, rd);
    check("R9 write in quiet period ignored", rd, 8'h00);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][23]) reg_wr(VEC[k][22:16], VEC[k][15:8]);
      else begin
        reg_rd(VEC[k][22:16], rd);
        check($sformatf("R%0d vector %0d", VEC[k][7:0], k), rd, VEC[k][15:8]);
      end
    end

    check("R12 avg port", avg_cfg, 8'h09);
    check("R6 low power set", low_power, 1'b1);
    reg_wr(7'h02, 8'h00);
    check("R6 low power cleared", low_power, 1'b0);

    tx_buf[0] = 8'h2E; tx_buf[1] = 8'h12; tx_buf[2] = 8'h34;
    run_frame(3);
    check("R1 R12 stream write gain", gain_word, 16'h1234);
    tx_buf[0] = 8'h24; tx_buf[1] = 8'hA1; tx_buf[2] = 8'h03; tx_buf[3] = 8'h00; tx_buf[4] = 8'h20;
    run_frame(5);
    check("R12 gp route", gp_route, 8'hA1);
    check("R12 irq route", irq_route, 8'h03);
    check("R12 timer", timer_cfg, 8'h20);
    reg_wr(7'h21, 8'h03);
    check("R12 op mode", op_mode, 2'd3);
    tx_buf[0] = 8'h8C; tx_buf[1] = 8'h00; tx_buf[2] = 8'h00;
    run_frame(3);
    check("R1 stream read hi", rx_buf[1], 8'h04);
    check("R1 stream read lo", rx_buf[2], 8'h56);

    cs_n = 0; wait_clk(HALF);
    send_bits(8'hFF, 5, r);
    wait_clk(HALF); cs_n = 1; wait_clk(2 * HALF);
    reg_wr(7'h0A, 8'hC3);
    reg_rd(7'h0A, rd);
    check("R11 partial byte dropped", rd, 8'hC3);
    cs_n = 0; wait_clk(HALF);
    send_bits(8'h0A, 8, r);
    send_bits(8'h00, 4, r);
    wait_clk(HALF); cs_n = 1; wait_clk(2 * HALF);
    reg_rd(7'h0A, rd);
    check("R11 truncated data byte", rd, 8'hC3);

    reg_wr(7'h20, 8'h01);
    check("R7 enter conversion", conv_active, 1'b1);
    reg_rd(7'h20, rd);
    check("R7 no read in conversion", rd, 8'h00);
    reg_wr(7'h0A, 8'h77);
    tx_buf[0] = 8'h55; run_frame(1);
    check("R7 other byte keeps mode", conv_active, 1'b1);
    tx_buf[0] = 8'hA8; run_frame(1);
    check("R7 exit command", conv_active, 1'b0);
    reg_rd(7'h0A, rd);
    check("R7 no write in conversion", rd, 8'hC3);
    reg_rd(7'h20, rd);
    check("R7 command reads zero", rd, 8'h00);

    load_pattern(1'b0);
    run_frame(18);
    reg_rd(7'h41, rd);
    check("R8 near miss no reset", rd, 8'h80);
    reg_rd(7'h0A, rd);
    check("R8 near miss scratch kept", rd, 8'hC3);

    reg_wr(7'h20, 8'h01);
    load_pattern(1'b1);
    run_frame(18);
    check("R8 conv cleared", conv_active, 1'b0);
    check("R8 gain restored", gain_word, 16'h8000);
    check("R8 timer restored", timer_cfg, 8'h00);
    reg_wr(7'h0A, 8'h66);
    wait_clk(HOLD_WAIT);
    reg_rd(7'h0A, rd);
    check("R8 R9 scratch after reset", rd, 8'h00);
    reg_rd(7'h41, rd);
    check("R10 status after soft reset", rd, 8'hC0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule